// File: doc/BRIEF.md
# Two-Frame SPI Front End for a 32-Pin Converter with GPIO Mode

This block is the serial target interface of a 32-pin multiplexed converter in which every pin can work either as an analog input or as a general-purpose pin. A host reads in two steps. It first sends a 16-bit command frame. It then deasserts chip select, reasserts it and clocks a second 16-bit frame, during which the block returns the requested value. The command picks either a configuration register or a conversion channel and gives a 5-bit address.

The block holds the per-pin mode bits in 8-bit configuration registers. These registers can be written with the same two-frame sequence, with the data in the low byte of the second frame. For a conversion read, the block presents the channel number on `conv_ch` and captures the 12-bit sample from `conv_data` when the second frame starts. The returned word carries a status bit that shows the channel is currently set up as a general-purpose pin.

All SPI pins are sampled with the block's own clock, which must run well above the serial clock.

Top module: `spi_adc_gpio_target`

## Requirements
- R1: After reset no command is pending, every pin is in analog mode (`pin_is_gpio` is all zero) and `miso` is 0.
- R2: Frames are 16 bits, most significant bit first, in SPI mode 0. MOSI is taken on the rising SCK edge and MISO changes only on the falling edge. The first bit is valid once chip select is asserted, and `miso` is 0 while `cs_n` is high.
- R3: A command word has bits 15:14 = 0, bit 13 = register flag (1 = configuration register, 0 = channel), bit 12 = direction (1 = read, 0 = write), bits 11:7 = address and bits 6:0 = 0. A word that breaks the zero fields is discarded, and the next frame is treated as a command frame that returns zeros.
- R4: A register read returns `{8'h00, value}`. Register k (k = 0..3) holds the modes of pins 8k..8k+7, with bit j standing for pin 8k+j. Any other register address reads 0.
- R5: A channel read drives the channel number on `conv_ch`, samples `conv_data` at the start of the second frame and returns `{1'b0, flag, 2'b00, sample[11:0]}`.
- R6: The flag in a channel read is 1 exactly when the addressed pin's mode bit is 1 (general-purpose), and 0 when the pin is analog.
- R7: A write command (register flag 1, direction 0) loads bits 7:0 of the second frame into the addressed register. Writes to an unmapped address, and writes with the register flag at 0, change nothing.
- R8: MOSI data in the second frame of a read changes no state.
- R9: If chip select rises before 16 bits have been clocked, the partial frame is dropped together with any pending command, and the next frame is a command frame.
- R10: A response is given only once: the frame after a completed second frame is decoded as a new command and returns zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| conv_ch | output | 5 | Channel addressed by the pending command |
| conv_data | input | 12 | Conversion sample for `conv_ch` |
| pin_is_gpio | output | 32 | Mode bit per pin, 1 = general-purpose |

## Verification
Channel reads are issued to pins whose mode bit is set and to pins whose mode bit is clear, including the edge pins 0 and 31. This separates a correct status flag from a stuck or misindexed one. Each channel returns a distinct sample, so a wrong channel or a shifted data field shows up in the returned word. The command decoder is tested with malformed words, writes to unmapped addresses, writes with the channel flag set, and all-ones MOSI during read responses; each of these must leave the registers untouched. Chip select is cut short in both the command frame and the data frame, and a third frame follows a completed read, so that the pending-command state is checked at each way it can be entered or left.

// File: rtl/spi_adc_gpio_target.sv
module spi_adc_gpio_target #(
  parameter int PINS = 32,
  parameter int DW   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             miso,
  output logic [4:0]       conv_ch,
  input  logic [DW-1:0]    conv_data,
  output logic [PINS-1:0]  pin_is_gpio
);
  localparam int FW   = 16;
  localparam int AW   = 5;
  localparam int NREG = PINS / 8;
  localparam int CW   = $clog2(FW + 1);

  logic [2:0]    sck_q, cs_q;
  logic [1:0]    mosi_q;
  logic [CW-1:0] cnt;
  logic [FW-1:0] sh_in, sh_out;
  logic          pend, p_reg, p_rd, in_data;
  logic [AW-1:0] p_addr;
  logic [PINS-1:0] mode;
  logic [7:0]    reg_rd;
  logic          gflag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire sel      = ~cs_q[1];
  wire cs_fall  = ~cs_q[1] & cs_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire done     = (cnt == CW'(FW));
  wire last     = sel & sck_rise & (cnt == CW'(FW - 1));
  wire [FW-1:0] word = {sh_in[FW-2:0], mosi_q[1]};
  wire cmd_ok   = (word[15:14] == 2'b00) && (word[6:0] == 7'd0);

  always_comb begin
    reg_rd = '0;
    for (int k = 0; k < NREG; k++)
      if (p_addr == AW'(k)) reg_rd = mode[k*8 +: 8];
  end

  assign gflag = (int'(p_addr) < PINS) ? mode[p_addr] : 1'b0;

  wire [FW-1:0] resp = p_reg ? {8'h00, reg_rd}
                             : {1'b0, gflag, 2'b00, 12'(conv_data)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      sh_in   <= '0;
      sh_out  <= '0;
      pend    <= 1'b0;
      p_reg   <= 1'b0;
      p_rd    <= 1'b0;
      p_addr  <= '0;
      in_data <= 1'b0;
      mode    <= '0;
    end else if (cs_fall) begin
      cnt     <= '0;
      in_data <= pend;
      sh_out  <= (pend && p_rd) ? resp : '0;
    end else if (cs_rise) begin
      sh_out <= '0;
      if (!done) pend <= 1'b0;
    end else if (sel) begin
      if (sck_rise && !done) begin
        sh_in <= word;
        cnt   <= cnt + 1'b1;
        if (cnt == CW'(FW - 1)) begin
          if (in_data) begin
            pend <= 1'b0;
            if (!p_rd && p_reg)
              for (int k = 0; k < NREG; k++)
                if (p_addr == AW'(k)) mode[k*8 +: 8] <= word[7:0];
          end else begin
            pend   <= cmd_ok;
            p_reg  <= word[13];
            p_rd   <= word[12];
            p_addr <= word[11:7];
          end
        end
      end
      if (sck_fall && cnt != '0 && !done)
        sh_out <= {sh_out[FW-2:0], 1'b0};
    end
  end

  assign miso        = ~cs_n & sh_out[FW-1];
  assign conv_ch     = p_addr;
  assign pin_is_gpio = mode;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FW));

  assert_miso_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !sck_fall && !cs_fall && !cs_rise) |=> $stable(sh_out[FW-1]));

  assert_bad_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !in_data && word[15:14] != 2'b00) |=> !pend);

  assert_ch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && in_data) |=> $stable(conv_ch));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(last && in_data) |=> $stable(pin_is_gpio));

  assert_partial_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !done) |=> !pend);

  assert_served_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (last && in_data) |=> !pend);
endmodule

// File: tb/spi_adc_gpio_target_tb.sv
module spi_adc_gpio_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic miso;
  logic [4:0] conv_ch;
  logic [11:0] conv_data;
  logic [31:0] pin_is_gpio;
  logic [31:0] exp_mode = '0;
  logic mon_en = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] smp(input logic [4:0] ch);
    return 12'({7'd0, ch}) * 12'd37 + 12'h1C3;
  endfunction

  assign conv_data = smp(conv_ch);

  spi_adc_gpio_target u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .conv_ch(conv_ch), .conv_data(conv_data),
    .pin_is_gpio(pin_is_gpio));

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // every-clock comparison against the bench's mode model while idle
  always @(negedge clk) begin
    if (mon_en && cs_n) begin
      check(pin_is_gpio === exp_mode, "R7 mode model", pin_is_gpio, exp_mode);
      check(miso === 1'b0, "R2 idle miso", {31'd0, miso}, 32'd0);
    end
  end

  function automatic logic [15:0] cmd(input bit rs, input bit rd, input logic [4:0] a);
    return {2'b00, rs, rd, a, 7'd0};
  endfunction

  task automatic frame(input logic [15:0] tx, input int nbits,
                       input logic [31:0] nxt, output logic [15:0] rx);
    int bad = 0;
    rx = '0;
    @(negedge clk) cs_n = 0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[15-i];
      repeat (HALF) @(negedge clk);
      rx[15-i] = miso;
      sck = 1;
      repeat (HALF) @(negedge clk);
      if (miso !== rx[15-i]) bad++;
      sck = 0;
    end
    check(bad == 0, "R2 miso stable while sck high", bad, 0);
    repeat (HALF) @(negedge clk);
    exp_mode = nxt;
    cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_rx(input logic [15:0] got, input logic [15:0] exp, input string req);
    check(got === exp, req, {16'd0, got}, {16'd0, exp});
  endtask

  task automatic rd_reg(input logic [4:0] a, input logic [7:0] v, input string req);
    logic [15:0] rx;
    frame(cmd(1, 1, a), 16, exp_mode, rx);
    expect_rx(rx, 16'd0, {req, " cmd frame"});
    frame(16'd0, 16, exp_mode, rx);
    expect_rx(rx, {8'h00, v}, req);
  endtask

  task automatic rd_conv(input logic [4:0] ch, input bit fl, input string req);
    logic [15:0] rx;
    frame(cmd(0, 1, ch), 16, exp_mode, rx);
    frame(16'd0, 16, exp_mode, rx);
    expect_rx(rx, {1'b0, fl, 2'b00, smp(ch)}, req);
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d, input logic [31:0] nxt);
    logic [15:0] rx;
    frame(cmd(1, 0, a), 16, exp_mode, rx);
    frame({8'h00, d}, 16, nxt, rx);
    expect_rx(rx, 16'd0, "R7 write response zero");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(pin_is_gpio === 32'd0, "R1 reset modes", pin_is_gpio, 0);
    check(miso === 1'b0, "R1 reset miso", {31'd0, miso}, 0);
    mon_en = 1;

    rd_conv(5'd5, 1'b0, "R5 channel read ch5");
    rd_conv(5'd17, 1'b0, "R5 channel read ch17");

    wr_reg(5'd1, 8'hA5, 32'h0000_A500);
    rd_reg(5'd1, 8'hA5, "R4 R7 register read after write");
    rd_conv(5'd8, 1'b1, "R6 flag set ch8");
    rd_conv(5'd9, 1'b0, "R6 flag clear ch9");

    wr_reg(5'd3, 8'h80, 32'h8000_A500);
    rd_conv(5'd31, 1'b1, "R6 flag set ch31");
    rd_conv(5'd0, 1'b0, "R6 flag clear ch0");
    rd_reg(5'd0, 8'h00, "R4 reg0");
    rd_reg(5'd3, 8'h80, "R4 reg3");
    rd_reg(5'd7, 8'h00, "R4 unmapped reads zero");

    wr_reg(5'd9, 8'hFF, exp_mode);
    for (int k = 0; k < 4; k++)
      rd_reg(5'(k), exp_mode[k*8 +: 8], "R7 unmapped write ignored");

    frame(cmd(0, 0, 5'd2), 16, exp_mode, rx);
    frame(16'h00FF, 16, exp_mode, rx);
    rd_reg(5'd0, 8'h00, "R7 channel-flag write ignored");

    frame(cmd(1, 1, 5'd1), 16, exp_mode, rx);
    frame(16'hFFFF, 16, exp_mode, rx);
    expect_rx(rx, 16'h00A5, "R8 read with all-ones mosi");
    rd_reg(5'd1, 8'hA5, "R8 no change after mosi noise");

    frame(16'hC000 | cmd(1, 1, 5'd1), 16, exp_mode, rx);
    frame(16'd0, 16, exp_mode, rx);
    expect_rx(rx, 16'd0, "R3 malformed top bits");
    frame(16'd0, 16, exp_mode, rx);
    frame(16'h0001 | cmd(1, 1, 5'd1), 16, exp_mode, rx);
    frame(16'd0, 16, exp_mode, rx);
    expect_rx(rx, 16'd0, "R3 malformed low bits");
    frame(16'd0, 16, exp_mode, rx);
    rd_reg(5'd1, 8'hA5, "R3 state intact");

    frame(cmd(1, 1, 5'd1), 8, exp_mode, rx);
    rd_conv(5'd8, 1'b1, "R9 after partial command frame");
    frame(cmd(1, 0, 5'd0), 16, exp_mode, rx);
    frame(16'h00FF, 6, exp_mode, rx);
    rd_reg(5'd0, 8'h00, "R9 partial data frame drops write");

    frame(cmd(1, 1, 5'd3), 16, exp_mode, rx);
    frame(16'd0, 16, exp_mode, rx);
    expect_rx(rx, 16'h0080, "R10 first response");
    frame(cmd(1, 1, 5'd1), 16, exp_mode, rx);
    expect_rx(rx, 16'd0, "R10 third frame is a command");
    frame(16'd0, 16, exp_mode, rx);
    expect_rx(rx, 16'h00A5, "R10 new response");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule